// File: doc/BRIEF.md
# Indirect Tile Map Pixel Renderer

This block produces the colour index stream for a 640x480 raster that is built from 8x8 tiles. It does not store pixels. A tile map memory holds one 16-bit entry for each cell of an 80x60 grid. A separate shape memory holds the tile bitmaps. For each cell the block reads the two map bytes and joins them into an entry. It then combines the entry's shape number with the current row inside the tile and fetches one bitmap row, and shifts that row out as eight pixels. Rewriting the two bytes of one entry therefore redraws a whole 8x8 square on screen.

The pixel and line counters come from an external timing generator. The block adds a fixed delay of one tile plus one register stage and marks the pixels it emits with a valid flag. The map memory has room for two complete maps, and a select input picks the one that is displayed, so software can build the other map without tearing. Display reads use only two cycles of every eight-pixel group. A processor write request is granted in every other cycle, and in every cycle during blanking.

Top module: `tilemap_render`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, colour_valid_o is 0 and colour_o is 0.
- R2: When pix_x_i < 640 and pix_y_i < 480 and pix_x_i mod 8 is 0, map_re_o is 1 and map_addr_o = bank + 2*((pix_y_i/8)*80 + pix_x_i/8). When pix_x_i mod 8 is 4, the same conditions apply and the address is one higher. These are the display read slots. Read data returns one cycle later.
- R3: The byte at the even address holds shape index bits 7:0. At the odd address, bits 1:0 hold shape index bits 9:8 and bits 7:2 hold the 6-bit foreground attribute.
- R4: In the cycle where pix_x_i mod 8 is 6 inside the active area, shape_re_o is 1 and shape_addr_o = {shape index, pix_y_i mod 8}. The shape byte returns one cycle later.
- R5: Each shape byte is one tile row at 1 bit per pixel, and bit 7 is the leftmost pixel. A set bit gives the attribute colour. A clear bit gives BG_INDEX, which is 0 by default.
- R6: The pixel at screen column sx, line sy appears on colour_o in the cycle after the counters show x = sx+8, y = sy. colour_valid_o is 1 in exactly these cycles.
- R7: map_sel_i = 0 selects the map at byte 0, and map_sel_i = 1 selects the map at byte 9600.
- R8: In a display read slot, cpu_ack_o is 0 and map_we_o is 0. In any other cycle, cpu_ack_o equals cpu_req_i, and a granted request drives map_we_o = 1 with cpu_addr_i and cpu_wdata_i on the map port.
- R9: After the two bytes of one entry are written, the next frame shows the new shape and colour over the entire 8x8 cell.
- R10: Outside the valid cycles, colour_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_x_i | input | 10 | Pixel counter within the line |
| pix_y_i | input | 10 | Line counter within the frame |
| map_sel_i | input | 1 | Chooses which of the two maps is displayed |
| cpu_req_i | input | 1 | Processor write request to map memory |
| cpu_addr_i | input | 15 | Processor write byte address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_ack_o | output | 1 | Write granted in this cycle |
| map_addr_o | output | 15 | Map memory byte address |
| map_re_o | output | 1 | Map memory read enable |
| map_we_o | output | 1 | Map memory write enable |
| map_wdata_o | output | 8 | Map memory write data |
| map_rdata_i | input | 8 | Map memory read data, one cycle latency |
| shape_addr_o | output | 13 | Shape memory row address |
| shape_re_o | output | 1 | Shape memory read enable |
| shape_rdata_i | input | 8 | Shape memory read data, one cycle latency |
| colour_o | output | 6 | Pixel colour index |
| colour_valid_o | output | 1 | Pixel colour is valid |

## Verification
The hardest case to reach is a processor write that lands in the same stretch of time as the display reads of that map. During active lines the stimulus therefore sends random write requests into the bank that is not shown. It then swaps the bank select between frames, so that the written contents are displayed. Writes into the shown bank are confined to vertical blanking, and their effect is checked over whole 8x8 cells in the next frame. Directed map entries place the largest shape index and unusual attributes in the last column and the last tile row. This exercises the high index bits and the edge of the pipeline window.

// File: rtl/tilemap_pkg.sv
package tilemap_pkg;
    localparam int TILE_PX = 8;
    localparam int ROW_W   = 3;
    localparam int IDX_W   = 10;
    localparam int ATTR_W  = 6;
    localparam int SHAPE_AW = IDX_W + ROW_W;

    typedef struct packed {
        logic [ATTR_W-1:0] attr;
        logic [IDX_W-1:0]  idx;
    } map_entry_t;
endpackage

// File: rtl/tilemap_fetch.sv
module tilemap_fetch
    import tilemap_pkg::*;
#(
    parameter int TILE_COLS = 80,
    parameter int TILE_ROWS = 60,
    parameter int X_W       = 10,
    parameter int Y_W       = 10,
    parameter int MAP_AW    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [X_W-1:0]      px_x,
    input  logic [Y_W-1:0]      px_y,
    input  logic                map_sel,
    input  logic [7:0]          map_rdata,
    input  logic [7:0]          shape_rdata,
    output logic                disp_rd,
    output logic [MAP_AW-1:0]   disp_addr,
    output logic                shape_re,
    output logic [SHAPE_AW-1:0] shape_addr,
    output logic [7:0]          nxt_bits,
    output logic [ATTR_W-1:0]   nxt_attr
);
    localparam int STRIDE = TILE_COLS * TILE_ROWS * 2;
    localparam logic [X_W-1:0] ACT_W = X_W'(TILE_COLS * TILE_PX);
    localparam logic [Y_W-1:0] ACT_H = Y_W'(TILE_ROWS * TILE_PX);

    typedef struct packed {
        logic [7:0]        lo;
        map_entry_t        ent;
        logic [7:0]        bits;
        logic [ATTR_W-1:0] attr;
    } fetch_t;

    fetch_t st_d, st_q;
    logic [ROW_W-1:0] phase;
    logic in_fetch;
    int   tile_num;

    always_comb begin
        phase    = px_x[ROW_W-1:0];
        in_fetch = (px_x < ACT_W) && (px_y < ACT_H);
        tile_num = int'(px_y >> ROW_W) * TILE_COLS + int'(px_x >> ROW_W);
        disp_rd  = in_fetch && (phase == 3'd0 || phase == 3'd4);
        disp_addr = MAP_AW'((map_sel ? STRIDE : 0) + tile_num * 2 + (phase[2] ? 1 : 0));
        shape_re   = in_fetch && (phase == 3'd6);
        shape_addr = {st_q.ent.idx, px_y[ROW_W-1:0]};

        st_d = st_q;
        if (in_fetch) begin
            case (phase)
                3'd1: st_d.lo  = map_rdata;
                3'd5: st_d.ent = map_entry_t'({map_rdata, st_q.lo});
                3'd7: begin
                    st_d.bits = shape_rdata;
                    st_d.attr = st_q.ent.attr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nxt_bits = st_q.bits;
    assign nxt_attr = st_q.attr;

    // R4: a shape read follows the second map byte read of the same tile
    p_shape_after_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shape_re |-> $past(disp_rd, 2));
endmodule

// File: rtl/tilemap_pixel.sv
module tilemap_pixel
    import tilemap_pkg::*;
#(
    parameter int TILE_COLS = 80,
    parameter int TILE_ROWS = 60,
    parameter int X_W       = 10,
    parameter int Y_W       = 10,
    parameter logic [ATTR_W-1:0] BG_INDEX = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [X_W-1:0]    px_x,
    input  logic [Y_W-1:0]    px_y,
    input  logic [7:0]        nxt_bits,
    input  logic [ATTR_W-1:0] nxt_attr,
    output logic [ATTR_W-1:0] colour,
    output logic              colour_valid
);
    localparam logic [X_W-1:0] OUT_LO = X_W'(TILE_PX);
    localparam logic [X_W-1:0] OUT_HI = X_W'(TILE_COLS * TILE_PX + TILE_PX);
    localparam logic [Y_W-1:0] ACT_H  = Y_W'(TILE_ROWS * TILE_PX);

    typedef struct packed {
        logic [7:0]        sh;
        logic [ATTR_W-1:0] attr;
        logic [ATTR_W-1:0] colour;
        logic              valid;
    } pix_t;

    pix_t st_d, st_q;
    logic out_act;
    logic [7:0] bits;
    logic [ATTR_W-1:0] att;

    always_comb begin
        out_act = (px_x >= OUT_LO) && (px_x < OUT_HI) && (px_y < ACT_H);
        bits = (px_x[ROW_W-1:0] == 3'd0) ? nxt_bits : st_q.sh;
        att  = (px_x[ROW_W-1:0] == 3'd0) ? nxt_attr : st_q.attr;
        st_d = st_q;
        st_d.valid  = out_act;
        st_d.colour = '0;
        if (out_act) begin
            st_d.sh     = {bits[6:0], 1'b0};
            st_d.attr   = att;
            st_d.colour = bits[7] ? att : BG_INDEX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign colour       = st_q.colour;
    assign colour_valid = st_q.valid;

    // R6: the valid window opens one tile after the line's first pixel
    p_first_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(colour_valid) |-> $past(px_x) == OUT_LO);
    // R10: valid output only comes from active lines
    p_valid_rows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        colour_valid |-> $past(px_y) < ACT_H);
endmodule

// File: rtl/tilemap_arb.sv
module tilemap_arb #(
    parameter int MAP_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_rd,
    input  logic [MAP_AW-1:0] disp_addr,
    input  logic              cpu_req,
    input  logic [MAP_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ack,
    output logic [MAP_AW-1:0] map_addr,
    output logic              map_re,
    output logic              map_we,
    output logic [7:0]        map_wdata
);
    always_comb begin
        cpu_ack   = cpu_req && !disp_rd;
        map_re    = disp_rd;
        map_we    = cpu_ack;
        map_addr  = disp_rd ? disp_addr : cpu_addr;
        map_wdata = cpu_wdata;
    end

    // R8: display reads own their slots
    p_no_ack_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_rd |-> !cpu_ack && !map_we);
    // R8: a request outside a slot is granted as a write
    p_free_slot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !disp_rd) |-> cpu_ack && map_we && map_addr == cpu_addr);
endmodule

// File: rtl/tilemap_render.sv
module tilemap_render
    import tilemap_pkg::*;
#(
    parameter int TILE_COLS = 80,
    parameter int TILE_ROWS = 60,
    parameter int X_W       = 10,
    parameter int Y_W       = 10,
    parameter int MAP_AW    = $clog2(4 * TILE_COLS * TILE_ROWS),
    parameter logic [ATTR_W-1:0] BG_INDEX = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [X_W-1:0]      pix_x_i,
    input  logic [Y_W-1:0]      pix_y_i,
    input  logic                map_sel_i,
    input  logic                cpu_req_i,
    input  logic [MAP_AW-1:0]   cpu_addr_i,
    input  logic [7:0]          cpu_wdata_i,
    output logic                cpu_ack_o,
    output logic [MAP_AW-1:0]   map_addr_o,
    output logic                map_re_o,
    output logic                map_we_o,
    output logic [7:0]          map_wdata_o,
    input  logic [7:0]          map_rdata_i,
    output logic [SHAPE_AW-1:0] shape_addr_o,
    output logic                shape_re_o,
    input  logic [7:0]          shape_rdata_i,
    output logic [ATTR_W-1:0]   colour_o,
    output logic                colour_valid_o
);
    logic              disp_rd;
    logic [MAP_AW-1:0] disp_addr;
    logic [7:0]        nxt_bits;
    logic [ATTR_W-1:0] nxt_attr;

    tilemap_fetch #(
        .TILE_COLS(TILE_COLS), .TILE_ROWS(TILE_ROWS),
        .X_W(X_W), .Y_W(Y_W), .MAP_AW(MAP_AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .px_x(pix_x_i), .px_y(pix_y_i),
        .map_sel(map_sel_i), .map_rdata(map_rdata_i), .shape_rdata(shape_rdata_i),
        .disp_rd(disp_rd), .disp_addr(disp_addr),
        .shape_re(shape_re_o), .shape_addr(shape_addr_o),
        .nxt_bits(nxt_bits), .nxt_attr(nxt_attr)
    );

    tilemap_arb #(.MAP_AW(MAP_AW)) u_arb (
        .clk(clk), .rst_n(rst_n), .disp_rd(disp_rd), .disp_addr(disp_addr),
        .cpu_req(cpu_req_i), .cpu_addr(cpu_addr_i), .cpu_wdata(cpu_wdata_i),
        .cpu_ack(cpu_ack_o), .map_addr(map_addr_o), .map_re(map_re_o),
        .map_we(map_we_o), .map_wdata(map_wdata_o)
    );

    tilemap_pixel #(
        .TILE_COLS(TILE_COLS), .TILE_ROWS(TILE_ROWS),
        .X_W(X_W), .Y_W(Y_W), .BG_INDEX(BG_INDEX)
    ) u_pixel (
        .clk(clk), .rst_n(rst_n), .px_x(pix_x_i), .px_y(pix_y_i),
        .nxt_bits(nxt_bits), .nxt_attr(nxt_attr),
        .colour(colour_o), .colour_valid(colour_valid_o)
    );
endmodule

// File: tb/test_tilemap_render.sv
module test_tilemap_render;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int AW = $clog2(4 * COLS * ROWS);
    localparam int STRIDE = COLS * ROWS * 2;
    localparam int ACT_W = COLS * 8;
    localparam int ACT_H = ROWS * 8;
    localparam int HT = 96;
    localparam int VT = 40;

    logic clk = 0, rst_n = 0;
    logic [9:0] pix_x = '0, pix_y = '0;
    logic map_sel = 0, cpu_req = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_ack, map_re, map_we, shape_re, colour_valid;
    logic [AW-1:0] map_addr;
    logic [7:0] map_wdata, map_rdata, shape_rdata;
    logic [12:0] shape_addr;
    logic [5:0] colour;
    logic [7:0] mem [0:4*COLS*ROWS-1];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tilemap_render #(.TILE_COLS(COLS), .TILE_ROWS(ROWS), .X_W(10), .Y_W(10), .MAP_AW(AW)) i_tilemap_render (
        .clk(clk), .rst_n(rst_n), .pix_x_i(pix_x), .pix_y_i(pix_y), .map_sel_i(map_sel),
        .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ack_o(cpu_ack),
        .map_addr_o(map_addr), .map_re_o(map_re), .map_we_o(map_we), .map_wdata_o(map_wdata),
        .map_rdata_i(map_rdata), .shape_addr_o(shape_addr), .shape_re_o(shape_re),
        .shape_rdata_i(shape_rdata), .colour_o(colour), .colour_valid_o(colour_valid)
    );

    function automatic logic [7:0] shape_fn(input logic [12:0] a);
        logic [12:0] t;
        t = a * 13'd157 + 13'd91;
        return t[7:0] ^ t[12:5];
    endfunction

    always @(posedge clk) begin
        if (map_re) map_rdata <= mem[map_addr];
        shape_rdata <= shape_fn(shape_addr);
    end

    function automatic int ent_base(input int sx, input int sy, input bit sel);
        return (sel ? STRIDE : 0) + ((sy / 8) * COLS + sx / 8) * 2;
    endfunction

    function automatic logic [5:0] exp_colour(input int sx, input int sy, input bit sel);
        int b;
        logic [9:0] idx;
        logic [7:0] bits;
        b = ent_base(sx, sy, sel);
        idx = {mem[b+1][1:0], mem[b]};
        bits = shape_fn({idx, 3'(sy % 8)});
        return bits[7 - sx % 8] ? mem[b+1][7:2] : 6'd0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        int px, py;
        bit psel, have_prev, pend;
        int pa;
        logic [7:0] pd;
        void'($urandom(32'd4242));
        foreach (mem[i]) mem[i] = 8'($urandom);
        have_prev = 0; pend = 0; pa = 0; pd = '0; px = 0; py = 0; psel = 0;
        repeat (3) @(negedge clk);
        check(colour_valid == 0 && colour == 0, "R1 reset", {colour_valid, colour}, 0);
        rst_n = 1;
        @(negedge clk);
        check(colour_valid == 0 && colour == 0, "R1 after reset", {colour_valid, colour}, 0);
        for (int f = 0; f < 6; f++) begin
            bit sel;
            sel = (f < 4) ? f[0] : 1'($urandom);
            if (f == 2) begin
                // R3 corner: largest shape index, last column, bank 0
                mem[14] = 8'hFF; mem[15] = 8'hFF;
                // R3 corner: index bit 9 only, last tile row
                mem[48] = 8'h00; mem[49] = 8'hAA;
            end
            for (int y = 0; y < VT; y++) begin
                for (int x = 0; x < HT; x++) begin
                    @(negedge clk);
                    if (pend) begin mem[pa] = pd; pend = 0; end
                    if (have_prev) begin
                        bit ev;
                        ev = (px >= 8) && (px < ACT_W + 8) && (py < ACT_H);
                        check(colour_valid == ev, "R6 valid", colour_valid, ev);
                        if (ev) begin
                            logic [5:0] ec;
                            ec = exp_colour(px - 8, py, psel);
                            check(colour == ec, "R5/R3/R7/R9 colour", colour, ec);
                        end else
                            check(colour == 0, "R10 idle colour", colour, 0);
                    end
                    pix_x = 10'(x); pix_y = 10'(y); map_sel = sel;
                    cpu_req = ($urandom % 3) == 0;
                    cpu_wdata = 8'($urandom);
                    if (y >= ACT_H) cpu_addr = AW'($urandom_range(0, 4 * COLS * ROWS - 1));
                    else            cpu_addr = AW'((sel ? 0 : STRIDE) + $urandom_range(0, STRIDE - 1));
                    #1;
                    if (x < ACT_W && y < ACT_H && (x % 8 == 0 || x % 8 == 4)) begin
                        int ea;
                        ea = ent_base(x, y, sel) + (x % 8 == 4 ? 1 : 0);
                        check(map_re == 1 && int'(map_addr) == ea, "R2/R7 read slot", map_addr, ea);
                        check(cpu_ack == 0 && map_we == 0, "R8 slot blocks cpu", cpu_ack, 0);
                    end else begin
                        check(cpu_ack == cpu_req, "R8 free slot grant", cpu_ack, cpu_req);
                        if (cpu_ack) begin
                            check(map_we && map_addr == cpu_addr && map_wdata == cpu_wdata,
                                  "R8 write port", map_addr, cpu_addr);
                            pend = 1; pa = int'(cpu_addr); pd = cpu_wdata;
                        end
                    end
                    if (x < ACT_W && y < ACT_H && x % 8 == 6) begin
                        int b;
                        logic [12:0] es;
                        b = ent_base(x, y, sel);
                        es = {mem[b+1][1:0], mem[b], 3'(y % 8)};
                        check(shape_re == 1 && shape_addr == es, "R4 shape address", shape_addr, es);
                    end
                    px = x; py = y; psel = sel; have_prev = 1;
                end
            end
        end
        summary();
    end
endmodule